// File: doc/BRIEF.md
# Serial-Comb CIC Decimator

This block is a four-stage cascaded integrator-comb decimator that runs on one fast clock. A signed sample enters the integrator chain on every cycle where `in_valid` is high. After every R accepted samples, the chain's last value is captured. The comb chain then reduces it to one decimated result. That result leaves on `out_data` with a one-cycle `out_valid` strobe. No divided or derived clock exists anywhere in the block.

The comb section works one bit per clock, least significant bit first. Each stage is a single-bit subtractor with one borrow flop and a delay shift register. A full comb pass therefore uses the idle input cycles between two decimated outputs, instead of four full-width subtractors. The ratio R and an output right shift are loaded at run time. The right shift removes the R^4 gain. A ratio is accepted only if it leaves enough clocks for a complete serial pass.

The internal word is ACC_W = IN_W + 4*RMAX_LOG bits. With the defaults this is 8 + 4*6 = 32 bits.

Top module: `cic_decim_serial`

## Requirements
- R1: `out_valid` is high for exactly one cycle per decimated result. It is never high on two consecutive cycles.
- R2: Number the samples accepted since the last accepted load (or since reset) from 0. Output m equals sum over j of h[j]·x[(m+1)R−1−j], where h holds the coefficients of ((1−z^−R)/(1−z^−1))^4. Samples before index 0 count as zero.
- R3: `out_valid` for output m rises ACC_W+1 clock edges after the edge that accepts sample (m+1)R−1.
- R4: Cycles with `in_valid` low add nothing to the integrators and do not advance the decimation count.
- R5: A load is accepted only if both of these hold: ACC_W+2 ≤ `cfg_ratio` ≤ 2^RMAX_LOG, and `cfg_shift` ≤ ACC_W. Any other load is rejected. A rejected load leaves the ratio, the shift and all filter state unchanged.
- R6: An accepted load clears the integrators, the comb delays, the decimation count and any result still in flight. The next edge therefore shows `out_valid` low.
- R7: The output is the exact filter value plus 2^(s−1) (added only when s > 0), arithmetically shifted right by s. The low OUT_W bits of that value are presented in two's complement.
- R8: `overrun` sets and stays set if a decimation point arrives while a serial comb pass is still running. It is cleared only by reset, and never sets while an accepted ratio is in force.
- R9: Right after reset, `out_valid`, `out_data` and `overrun` are zero. The ratio is DEF_RATIO (64) and the shift is DEF_SHIFT (24).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single input-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | IN_W | Signed input sample |
| in_valid | input | 1 | Input sample qualifier |
| cfg_load | input | 1 | Load request for ratio and shift |
| cfg_ratio | input | RMAX_LOG+1 | Requested decimation ratio |
| cfg_shift | input | SH_W | Requested output right shift |
| out_data | output | OUT_W | Scaled decimated sample |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| overrun | output | 1 | Sticky serial-comb overrun flag |

## Verification
The checker module tests four properties on every cycle:
- the strobe lasts one cycle;
- the stored ratio never leaves its legal range;
- a rejected load leaves ratio and shift untouched;
- an accepted load silences the output on the next edge.

It also checks that the overrun flag stays low. The bench sweeps several ratios, shifts and stimulus shapes, including full-scale constants, an impulse, alternating extremes and gapped input. Only those scenarios can show that the numerical results match the CIC response, the rounding and the truncation. They also show the exact output latency and that an interrupted pass leaves no trace.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // One bit of a - b computed as a + ~b + c; returns {carry_out, diff_bit}.
  function automatic logic [1:0] ser_sub(input logic a, input logic b, input logic c);
    logic nb;
    nb = ~b;
    return {(a & nb) | (a & c) | (nb & c), a ^ nb ^ c};
  endfunction
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int IN_W   = 8,
  parameter int ACC_W  = 32,
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  output logic [ACC_W-1:0]        last_next
);
  logic [ACC_W-1:0] sum_q [STAGES];
  logic [ACC_W-1:0] sum_d [STAGES];

  // Ripple form: each stage adds the freshly updated value of the stage before.
  always_comb begin
    sum_d[0] = sum_q[0] + {{(ACC_W-IN_W){din[IN_W-1]}}, din};
    for (int k = 1; k < STAGES; k++) begin
      sum_d[k] = sum_q[k] + sum_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < STAGES; k++) sum_q[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < STAGES; k++) sum_q[k] <= sum_d[k];
    end
  end

  assign last_next = sum_d[STAGES-1];
endmodule

// File: rtl/cic_comb_bit.sv
module cic_comb_bit #(
  parameter int ACC_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic step,
  input  logic bit_in,
  output logic bit_out
);
  logic [ACC_W-1:0] dly_q;
  logic             cy_q;
  logic [1:0]       res;

  assign res     = cic_pkg::ser_sub(bit_in, dly_q[0], cy_q);
  assign bit_out = res[0];

  // The delay word rotates LSB-first: the old bit leaves as the new one enters.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dly_q <= '0;
      cy_q  <= 1'b1;
    end else if (start) begin
      cy_q  <= 1'b1;
    end else if (step) begin
      dly_q <= {bit_in, dly_q[ACC_W-1:1]};
      cy_q  <= res[1];
    end
  end
endmodule

// File: rtl/cic_round.sv
module cic_round #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 12,
  parameter int SH_W  = 6
) (
  input  logic [ACC_W-1:0] din,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] dout
);
  logic signed [ACC_W:0] ext, half, sum, shd;

  always_comb begin
    ext  = $signed({din[ACC_W-1], din});
    half = '0;
    if (shamt != '0) half = (ACC_W+1)'(1) << (shamt - 1'b1);
    sum  = ext + half;
    shd  = sum >>> shamt;
    dout = shd[OUT_W-1:0];
  end
endmodule

// File: rtl/cic_decim_serial.sv
module cic_decim_serial #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 12,
  parameter int STAGES    = 4,
  parameter int RMAX_LOG  = 6,
  parameter int SH_W      = 6,
  parameter int DEF_RATIO = 64,
  parameter int DEF_SHIFT = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     in_valid,
  input  logic                     cfg_load,
  input  logic [RMAX_LOG:0]        cfg_ratio,
  input  logic [SH_W-1:0]          cfg_shift,
  output logic [OUT_W-1:0]         out_data,
  output logic                     out_valid,
  output logic                     overrun
);
  localparam int RAT_W  = RMAX_LOG + 1;
  localparam int ACC_W  = IN_W + STAGES * RMAX_LOG;
  localparam int R_MAX  = 1 << RMAX_LOG;
  localparam int R_MIN  = ACC_W + 2;
  localparam int BIT_CW = $clog2(ACC_W);

  logic [RAT_W-1:0]  ratio_q, cnt_q;
  logic [SH_W-1:0]   shift_q;
  logic              busy_q, done_q;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic [ACC_W-1:0]  snap_q, res_q, acc_next;
  logic [OUT_W-1:0]  scaled;
  logic              cfg_ok, clr, accept, tick, start;
  logic              chain [STAGES+1];

  assign cfg_ok = (cfg_ratio >= RAT_W'(R_MIN)) && (cfg_ratio <= RAT_W'(R_MAX)) &&
                  (cfg_shift <= SH_W'(ACC_W));
  assign clr    = cfg_load && cfg_ok;
  assign accept = in_valid && !clr;
  assign tick   = accept && (cnt_q == ratio_q - 1'b1);
  assign start  = tick && !busy_q;

  cic_integ #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst(rst), .clr(clr), .en(accept), .din(in_data), .last_next(acc_next)
  );

  assign chain[0] = snap_q[0];
  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    cic_comb_bit #(.ACC_W(ACC_W)) u_stage (
      .clk(clk), .rst(rst), .clr(clr), .start(start), .step(busy_q),
      .bit_in(chain[g]), .bit_out(chain[g+1])
    );
  end

  cic_round #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_round (
    .din(res_q), .shamt(shift_q), .dout(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q   <= RAT_W'(DEF_RATIO);
      shift_q   <= SH_W'(DEF_SHIFT);
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      bit_cnt_q <= '0;
      snap_q    <= '0;
      res_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (clr) begin
        ratio_q <= cfg_ratio;
        shift_q <= cfg_shift;
        cnt_q   <= '0;
        busy_q  <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (accept) cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (start) begin
          snap_q    <= acc_next;
          busy_q    <= 1'b1;
          bit_cnt_q <= '0;
        end else if (busy_q) begin
          snap_q    <= snap_q >> 1;
          res_q     <= {chain[STAGES], res_q[ACC_W-1:1]};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BIT_CW'(ACC_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        if (tick && busy_q) overrun <= 1'b1;
        if (done_q) begin
          out_valid <= 1'b1;
          out_data  <= scaled;
          done_q    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cic_decim_serial_chk.sv
module cic_decim_serial_chk #(
  parameter int RAT_W = 7,
  parameter int SH_W  = 6,
  parameter int R_MIN = 34,
  parameter int R_MAX = 64,
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [RAT_W-1:0] cfg_ratio,
  input logic [SH_W-1:0]  cfg_shift,
  input logic             out_valid,
  input logic             overrun,
  input logic [RAT_W-1:0] ratio_q,
  input logic [SH_W-1:0]  shift_q
);
  logic req_ok;
  assign req_ok = (cfg_ratio >= RAT_W'(R_MIN)) && (cfg_ratio <= RAT_W'(R_MAX)) &&
                  (cfg_shift <= SH_W'(ACC_W));

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R1
  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (ratio_q >= RAT_W'(R_MIN)) && (ratio_q <= RAT_W'(R_MAX))); // R5
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && !req_ok) |=> ($stable(ratio_q) && $stable(shift_q))); // R5
  AST_LOAD_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && req_ok) |=> !out_valid); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    !overrun); // R8
endmodule

bind cic_decim_serial cic_decim_serial_chk #(
  .RAT_W(RAT_W), .SH_W(SH_W), .R_MIN(R_MIN), .R_MAX(R_MAX), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ratio(cfg_ratio),
  .cfg_shift(cfg_shift), .out_valid(out_valid), .overrun(overrun),
  .ratio_q(ratio_q), .shift_q(shift_q)
);

// File: tb/cic_decim_serial_tb.sv
module cic_decim_serial_tb;
  localparam int IN_W = 8, OUT_W = 12, STAGES = 4, RMAX_LOG = 6, SH_W = 6;
  localparam int ACC_W = IN_W + STAGES * RMAX_LOG;

  logic clk = 1'b0, rst = 1'b1;
  logic signed [IN_W-1:0] in_data = '0;
  logic in_valid = 1'b0, cfg_load = 1'b0;
  logic [RMAX_LOG:0] cfg_ratio = '0;
  logic [SH_W-1:0] cfg_shift = '0;
  logic [OUT_W-1:0] out_data;
  logic out_valid, overrun;

  cic_decim_serial u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .cfg_load(cfg_load), .cfg_ratio(cfg_ratio), .cfg_shift(cfg_shift),
    .out_data(out_data), .out_valid(out_valid), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  int cur_r, cur_s, nx, ng, mchk;
  longint xs [0:2047];
  int     tcyc [0:63];
  longint got [0:63];
  int     gcyc [0:63];
  longint h [0:255];
  int     hlen;
  bit     prev_v = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Output monitor; also checks the one-cycle strobe (R1).
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && prev_v) check(1'b0, "R1 strobe longer than one cycle", 1, 0);
      if (out_valid) begin
        if (ng < 64) begin
          got[ng]  = longint'($signed(out_data));
          gcyc[ng] = cyc;
        end
        ng++;
      end
    end
    prev_v = out_valid;
  end

  function automatic void make_h(input int r);
    longint tmp [0:255];
    for (int k = 0; k < 256; k++) h[k] = 0;
    h[0] = 1;
    hlen = 1;
    for (int st = 0; st < STAGES; st++) begin
      for (int k = 0; k < hlen + r - 1; k++) begin
        tmp[k] = 0;
        for (int j = 0; j < r; j++) if (k - j >= 0 && k - j < hlen) tmp[k] += h[k-j];
      end
      hlen = hlen + r - 1;
      for (int k = 0; k < hlen; k++) h[k] = tmp[k];
    end
  endfunction

  function automatic longint expect_out(input int m);
    longint acc = 0, v;
    int n = (m + 1) * cur_r - 1;
    for (int j = 0; j < hlen; j++) if (n - j >= 0) acc += h[j] * xs[n-j];
    if (cur_s == 0) v = acc;
    else v = (acc + (64'sd1 <<< (cur_s - 1))) >>> cur_s;
    v = longint'($signed(v[OUT_W-1:0]));
    return v;
  endfunction

  function automatic longint samp(input int pat, input int i);
    case (pat)
      0: return longint'(int'($urandom_range(255)) - 128);
      1: return 127;
      2: return -128;
      3: return (i == 0) ? 100 : 0;
      default: return (i % 2 == 1) ? -128 : 127;
    endcase
  endfunction

  task automatic load_ok(input int r, input int s);
    @(negedge clk);
    in_valid = 1'b0; cfg_load = 1'b1; cfg_ratio = (RMAX_LOG+1)'(r); cfg_shift = SH_W'(s);
    cur_r = r; cur_s = s; nx = 0; ng = 0; mchk = 0;
    make_h(r);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic load_bad(input int r, input int s);
    @(negedge clk);
    in_valid = 1'b0; cfg_load = 1'b1; cfg_ratio = (RMAX_LOG+1)'(r); cfg_shift = SH_W'(s);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Drives samples with no expectation (used before an interrupting load).
  task automatic feed_only(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_data = IN_W'(int'($urandom_range(255)) - 128); in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stream(input int nout, input int pat, input bit gaps, input string tag);
    longint v;
    for (int i = 0; i < nout * cur_r; i++) begin
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '1;
      end
      @(negedge clk);
      v = samp(pat, nx);
      in_data = IN_W'(v); in_valid = 1'b1;
      xs[nx] = v;
      if ((nx + 1) % cur_r == 0) tcyc[(nx + 1) / cur_r - 1] = cyc + 1;
      nx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (ACC_W + 6) @(negedge clk);
    check(ng == nx / cur_r, {tag, " R1 output count"}, ng, nx / cur_r);
    for (int m = mchk; m < nx / cur_r && m < ng; m++) begin
      check(got[m] == expect_out(m), {tag, " R2 R7 value"}, got[m], expect_out(m));
      check(gcyc[m] - tcyc[m] == ACC_W + 1, {tag, " R3 latency"}, gcyc[m] - tcyc[m], ACC_W + 1);
    end
    check(overrun == 1'b0, {tag, " R8 overrun"}, overrun, 0);
    mchk = nx / cur_r;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(out_data == '0, "R9 reset out_data", out_data, 0);
    check(overrun == 1'b0, "R9 reset overrun", overrun, 0);
    // Defaults after reset: ratio 64, shift 24.
    cur_r = 64; cur_s = 24; nx = 0; ng = 0; mchk = 0;
    make_h(64);
    stream(3, 0, 1'b0, "R9 default config");
    load_ok(34, 0);  stream(4, 0, 1'b0, "R2 min ratio raw");
    stream(3, 1, 1'b0, "R2 full-scale positive");
    load_ok(64, 24); stream(3, 2, 1'b0, "R7 full-scale negative");
    load_ok(64, 20); stream(3, 4, 1'b0, "R7 truncation alternating");
    load_ok(40, 13); stream(4, 3, 1'b0, "R2 impulse");
    stream(3, 0, 1'b1, "R4 gapped input");
    load_bad(33, 5); load_bad(65, 5); load_bad(50, 33);
    stream(3, 0, 1'b0, "R5 rejected loads");
    load_ok(34, 1);  stream(4, 0, 1'b0, "R7 half-up rounding");
    load_ok(50, 17); feed_only(70);
    load_ok(45, 16); stream(3, 0, 1'b0, "R6 load clears in-flight");
    stream(3, 4, 1'b1, "R6 gapped after load");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule